// File: doc/BRIEF.md
# Two-Slot Oldest-Ready Issue Station

This block sits in front of a single execution unit. It buffers up to two instructions that are waiting on source operands. Each stored source keeps a producer tag and a ready flag. A result bus carries the tags of values that have just been produced. When a tag on that bus matches, the stored source becomes ready.

On every cycle the station offers at most one instruction to the unit. An instruction is eligible only when all its sources are ready. When both slots are eligible, the instruction accepted earlier goes first. A blocked older instruction can stay in one slot while younger independent instructions pass through the other slot. The block does not try to prevent this starvation.

A parameter reduces the station to one slot. In that configuration, instructions leave strictly in the order they arrived. Only the values 1 and 2 are meaningful for the slot count. The station has a valid/ready input handshake, a result-tag input and a valid/ready issue output. A flush input empties it in one cycle.

Top module: `issue_rs`

## Requirements
- R1: After reset the station is empty: `out_valid` is 0 and `in_ready` is 1.
- R2: `out_valid` is 1 exactly when some held instruction has every source ready. The payload presented is that of an instruction with every source ready.
- R3: When both held instructions have every source ready, the one accepted earlier is presented first.
- R4: An instruction with a source not ready stays held for any number of cycles. Meanwhile, later ready instructions are accepted and issued through the other slot.
- R5: A `wb_valid` cycle whose `wb_tag` equals a held source's tag makes that source ready. The effect is visible from the next cycle on, and a ready source never becomes unready while its instruction is held.
- R6: If an instruction is accepted in the same cycle that its source tag appears on the result bus, that source is captured as ready.
- R7: `in_ready` is 0 when every slot is occupied and no issue handshake (`out_valid` and `out_ready` both 1) occurs in that cycle. Otherwise it is 1, unless `flush` is high.
- R8: A held instruction leaves only through an issue handshake or a flush. While `out_ready` is 0, `out_valid` stays 1 once raised.
- R9: A cycle with `flush` at 1 empties every slot by the next cycle and accepts no new instruction (`in_ready` is 0 during it).
- R10: With `NUM_SLOTS` = 1 the station holds one instruction. It issues instructions in arrival order and refuses input while its instruction is held and not issuing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| flush | input | 1 | Empties every slot at the next edge |
| in_valid | input | 1 | New instruction offered |
| in_ready | output | 1 | Station accepts the offered instruction this cycle |
| in_payload | input | PAY_W | Opaque instruction word |
| in_src_tag | input | NSRC*TAG_W | Producer tag of each source, source j at bits [j*TAG_W +: TAG_W] |
| in_src_rdy | input | NSRC | Source j already available (bit j) |
| wb_valid | input | 1 | A result tag is broadcast this cycle |
| wb_tag | input | TAG_W | Tag of the broadcast result |
| out_valid | output | 1 | An instruction is presented to the unit |
| out_ready | input | 1 | Unit takes the presented instruction |
| out_payload | output | PAY_W | Word of the presented instruction |

## Verification
The embedded properties check several things on every cycle. A presented instruction corresponds to exactly one held slot whose sources are all ready. A held ready source never drops. A stalled offer is not withdrawn, and a flush leaves nothing behind. The occupancy never grows without an input handshake. The age pointer stays put while both slots are held and the older one does not leave.

Only the bench scenarios can show the rest. One is that the older of two ready instructions really goes first. Another is that a blocked instruction is overtaken by a stream of younger ones. The bench also shows the same-cycle capture of a broadcast at acceptance, and the strict ordering of the one-slot variant. A reference model in the bench follows a long pseudo-random sequence against both configurations.

// File: rtl/issue_rs_pkg.sv
package issue_rs_pkg;

  typedef enum logic {
    SLOT_A = 1'b0,
    SLOT_B = 1'b1
  } slot_id_e;

  function automatic slot_id_e other_slot(input slot_id_e s);
    return (s == SLOT_A) ? SLOT_B : SLOT_A;
  endfunction

endpackage

// File: rtl/issue_rs_slot.sv
module issue_rs_slot #(
  parameter int TAG_W = 4,
  parameter int PAY_W = 32,
  parameter int NSRC  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               alloc,
  input  logic [PAY_W-1:0]   alloc_payload,
  input  logic [NSRC*TAG_W-1:0] alloc_tags,
  input  logic [NSRC-1:0]    alloc_rdy,
  input  logic               wb_valid,
  input  logic [TAG_W-1:0]   wb_tag,
  input  logic               release_i,
  output logic               occupied,
  output logic               all_ready,
  output logic [PAY_W-1:0]   payload
);

  logic                    valid_q, valid_d;
  logic [NSRC-1:0]         rdy_q, rdy_d;
  logic [NSRC-1:0]         wb_hit, new_hit;
  logic [NSRC*TAG_W-1:0]   tag_q;
  logic [PAY_W-1:0]        pay_q;
  logic                    load_en;

  always_comb begin
    for (int j = 0; j < NSRC; j++) begin
      wb_hit[j]  = valid_q && wb_valid && (tag_q[j*TAG_W +: TAG_W] == wb_tag);
      new_hit[j] = wb_valid && (alloc_tags[j*TAG_W +: TAG_W] == wb_tag);
    end
    load_en = alloc && !flush;
    valid_d = valid_q;
    rdy_d   = rdy_q | wb_hit;
    if (flush) begin
      valid_d = 1'b0;
    end else if (alloc) begin
      valid_d = 1'b1;
      rdy_d   = alloc_rdy | new_hit;
    end else if (release_i) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      rdy_q   <= '0;
    end else begin
      valid_q <= valid_d;
      rdy_q   <= rdy_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      tag_q <= alloc_tags;
      pay_q <= alloc_payload;
    end
  end

  assign occupied  = valid_q;
  assign all_ready = valid_q && (&rdy_q);
  assign payload   = pay_q;

  for (genvar j = 0; j < NSRC; j++) begin : g_wake_chk
    // R5
    wake_sets_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !flush && !alloc && !release_i && wb_valid &&
       tag_q[j*TAG_W +: TAG_W] == wb_tag) |=> rdy_q[j]);
    // R5
    rdy_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && rdy_q[j] && !flush && !alloc && !release_i) |=> rdy_q[j]);
  end

endmodule

// File: rtl/issue_rs_pick.sv
module issue_rs_pick
  import issue_rs_pkg::*;
#(
  parameter int NUM_SLOTS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic [NUM_SLOTS-1:0] slot_valid,
  input  logic [NUM_SLOTS-1:0] slot_rdy,
  input  logic                 in_valid,
  input  logic                 out_ready,
  output logic                 issue_valid,
  output logic                 issue_idx,
  output logic                 in_ready,
  output logic [NUM_SLOTS-1:0] alloc_vec,
  output logic [NUM_SLOTS-1:0] release_vec
);

  slot_id_e old_q, old_d;

  if (NUM_SLOTS == 1) begin : g_one
    always_comb begin
      issue_valid    = slot_rdy[0];
      issue_idx      = (old_q == SLOT_B);
      in_ready       = !flush && (!slot_valid[0] || (slot_rdy[0] && out_ready));
      alloc_vec[0]   = in_valid && in_ready;
      release_vec[0] = issue_valid && out_ready;
      old_d          = SLOT_A;
    end
  end else begin : g_two
    logic     both, fire, alloc_go;
    slot_id_e alloc_idx;
    logic [1:0] after;

    always_comb begin
      both        = slot_rdy[0] && slot_rdy[1];
      issue_valid = slot_rdy[0] || slot_rdy[1];
      issue_idx   = both ? (old_q == SLOT_B) : slot_rdy[1];
      fire        = issue_valid && out_ready;
      in_ready    = !flush && (!(&slot_valid) || fire);
      alloc_go    = in_valid && in_ready;
      if (!slot_valid[0])      alloc_idx = SLOT_A;
      else if (!slot_valid[1]) alloc_idx = SLOT_B;
      else                     alloc_idx = slot_id_e'(issue_idx);
      alloc_vec[0]   = alloc_go && (alloc_idx == SLOT_A);
      alloc_vec[1]   = alloc_go && (alloc_idx == SLOT_B);
      release_vec[0] = fire && !issue_idx;
      release_vec[1] = fire && issue_idx;
      after = (slot_valid & ~release_vec) | alloc_vec;
      old_d = old_q;
      if (flush)           old_d = SLOT_A;
      else if (&after)     old_d = alloc_go ? other_slot(alloc_idx) : old_q;
      else if (after[1])   old_d = SLOT_B;
      else if (after[0])   old_d = SLOT_A;
    end

    // R4
    age_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((&slot_valid) && !flush &&
       !(issue_valid && out_ready && (issue_idx == (old_q == SLOT_B))))
      |=> (old_q == $past(old_q)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) old_q <= SLOT_A;
    else        old_q <= old_d;
  end

endmodule

// File: rtl/issue_rs.sv
module issue_rs #(
  parameter int NUM_SLOTS = 2,
  parameter int TAG_W     = 4,
  parameter int PAY_W     = 32,
  parameter int NSRC      = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [PAY_W-1:0]       in_payload,
  input  logic [NSRC*TAG_W-1:0]  in_src_tag,
  input  logic [NSRC-1:0]        in_src_rdy,
  input  logic                   wb_valid,
  input  logic [TAG_W-1:0]       wb_tag,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [PAY_W-1:0]       out_payload
);

  localparam int SRC_BITS = NSRC * TAG_W;

  logic [NUM_SLOTS-1:0] slot_valid, slot_rdy, alloc_vec, release_vec;
  logic [PAY_W-1:0]     slot_pay [NUM_SLOTS];
  logic                 issue_idx;
  logic [SRC_BITS-1:0]  src_tags;

  assign src_tags = in_src_tag;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    issue_rs_slot #(
      .TAG_W (TAG_W),
      .PAY_W (PAY_W),
      .NSRC  (NSRC)
    ) u_slot (
      .clk           (clk),
      .rst_n         (rst_n),
      .flush         (flush),
      .alloc         (alloc_vec[s]),
      .alloc_payload (in_payload),
      .alloc_tags    (src_tags),
      .alloc_rdy     (in_src_rdy),
      .wb_valid      (wb_valid),
      .wb_tag        (wb_tag),
      .release_i     (release_vec[s]),
      .occupied      (slot_valid[s]),
      .all_ready     (slot_rdy[s]),
      .payload       (slot_pay[s])
    );
  end

  issue_rs_pick #(
    .NUM_SLOTS (NUM_SLOTS)
  ) u_pick (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .slot_valid  (slot_valid),
    .slot_rdy    (slot_rdy),
    .in_valid    (in_valid),
    .out_ready   (out_ready),
    .issue_valid (out_valid),
    .issue_idx   (issue_idx),
    .in_ready    (in_ready),
    .alloc_vec   (alloc_vec),
    .release_vec (release_vec)
  );

  if (NUM_SLOTS == 1) begin : g_mux1
    assign out_payload = slot_pay[0];
  end else begin : g_mux2
    assign out_payload = slot_pay[issue_idx];
  end

  // R2
  issue_from_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |->
      ($countones(release_vec) == 1) && (|(release_vec & slot_rdy & slot_valid)));
  // R8
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> out_valid);
  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (slot_valid == '0) && !out_valid);
  // R7
  no_silent_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> ($countones(slot_valid) <= $countones($past(slot_valid))));

endmodule

// File: tb/test_issue_rs.sv
module test_issue_rs;

  localparam int PERIOD = 10;
  localparam int TW = 3;
  localparam int PW = 8;

  logic clk, rst_n;
  logic fl, iv, wbv, ordy;
  logic [PW-1:0]   ipay;
  logic [2*TW-1:0] itag;
  logic [1:0]      irdy;
  logic [TW-1:0]   wbt;
  logic ir2, ov2, ir1, ov1;
  logic [PW-1:0] op2, op1;

  int n_chk = 0;
  int n_fail = 0;

  issue_rs #(.NUM_SLOTS(2), .TAG_W(TW), .PAY_W(PW), .NSRC(2)) i_issue_rs (
    .clk(clk), .rst_n(rst_n), .flush(fl), .in_valid(iv), .in_ready(ir2),
    .in_payload(ipay), .in_src_tag(itag), .in_src_rdy(irdy),
    .wb_valid(wbv), .wb_tag(wbt), .out_valid(ov2), .out_ready(ordy),
    .out_payload(op2));

  issue_rs #(.NUM_SLOTS(1), .TAG_W(TW), .PAY_W(PW), .NSRC(2)) i_issue_rs_one (
    .clk(clk), .rst_n(rst_n), .flush(fl), .in_valid(iv), .in_ready(ir1),
    .in_payload(ipay), .in_src_tag(itag), .in_src_rdy(irdy),
    .wb_valid(wbv), .wb_tag(wbt), .out_valid(ov1), .out_ready(ordy),
    .out_payload(op1));

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  // reference model, index [config][slot], config 0 = two slots, 1 = one slot
  logic          mv [2][2];
  logic [PW-1:0] mp [2][2];
  logic [TW-1:0] mt [2][2][2];
  logic          mr [2][2][2];
  int            ms [2][2];
  int            seqc = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic put(input logic v, input logic [PW-1:0] p, input logic [2*TW-1:0] t,
                     input logic [1:0] r, input logic bv, input logic [TW-1:0] bt,
                     input logic o, input logic f);
    iv = v; ipay = p; itag = t; irdy = r; wbv = bv; wbt = bt; ordy = o; fl = f;
  endtask

  task automatic idle(input logic o);
    put(1'b0, '0, '0, 2'b00, 1'b0, '0, o, 1'b0);
  endtask

  // called just after a falling edge with inputs set; compares, then advances the model
  task automatic step();
    logic ev [2];
    logic eir [2];
    logic rr [2][2];
    int   pk [2];
    #2;
    for (int d = 0; d < 2; d++) begin
      int cap;
      logic fr;
      string rq;
      cap = (d == 0) ? 2 : 1;
      fr = 1'b0;
      for (int s = 0; s < 2; s++) begin
        rr[d][s] = (s < cap) && mv[d][s] && mr[d][s][0] && mr[d][s][1];
        if (s < cap && !mv[d][s]) fr = 1'b1;
      end
      ev[d] = rr[d][0] || rr[d][1];
      if (rr[d][0] && rr[d][1]) pk[d] = (ms[d][0] < ms[d][1]) ? 0 : 1;
      else                      pk[d] = rr[d][0] ? 0 : 1;
      eir[d] = !fl && (fr || (ev[d] && ordy));
      rq = (d == 1) ? "R10" : (fl ? "R9" : "R7");
      chk(rq, (d == 0) ? 32'(ir2) : 32'(ir1), 32'(eir[d]));
      rq = (d == 1) ? "R10" : "R2";
      chk(rq, (d == 0) ? 32'(ov2) : 32'(ov1), 32'(ev[d]));
      if (ev[d]) begin
        rq = (d == 1) ? "R10" : ((rr[d][0] && rr[d][1]) ? "R3" : "R2");
        chk(rq, (d == 0) ? 32'(op2) : 32'(op1), 32'(mp[d][pk[d]]));
      end
    end
    @(posedge clk);
    for (int d = 0; d < 2; d++) begin
      int cap;
      logic done;
      cap = (d == 0) ? 2 : 1;
      if (fl) begin
        for (int s = 0; s < 2; s++) mv[d][s] = 1'b0;
      end else begin
        if (ev[d] && ordy) mv[d][pk[d]] = 1'b0;
        for (int s = 0; s < cap; s++)
          for (int j = 0; j < 2; j++)
            if (mv[d][s] && wbv && mt[d][s][j] == wbt) mr[d][s][j] = 1'b1;
        done = 1'b0;
        if (iv && eir[d]) begin
          for (int s = 0; s < cap; s++) begin
            if (!done && !mv[d][s]) begin
              done = 1'b1;
              mv[d][s] = 1'b1;
              mp[d][s] = ipay;
              ms[d][s] = seqc;
              for (int j = 0; j < 2; j++) begin
                mt[d][s][j] = itag[j*TW +: TW];
                mr[d][s][j] = irdy[j] || (wbv && itag[j*TW +: TW] == wbt);
              end
            end
          end
        end
      end
    end
    seqc++;
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < 2; s++) begin
        mv[d][s] = 1'b0; mp[d][s] = '0; ms[d][s] = 0;
        for (int j = 0; j < 2; j++) begin mt[d][s][j] = '0; mr[d][s][j] = 1'b0; end
      end
    rst_n = 1'b0;
    idle(1'b1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    idle(1'b1);
    #1;
    chk("R1", 32'(ov2), 0); chk("R1", 32'(ir2), 1);
    chk("R1", 32'(ov1), 0); chk("R1", 32'(ir1), 1);
    step();

    // R4: blocked instruction, younger ones stream past
    put(1'b1, 8'hA0, {3'd5, 3'd5}, 2'b00, 1'b0, '0, 1'b1, 1'b0); step();
    for (int k = 1; k <= 3; k++) begin
      put(1'b1, 8'hB0 + 8'(k), 6'd0, 2'b11, 1'b0, '0, 1'b1, 1'b0); step();
    end
    idle(1'b1); step();
    idle(1'b1);
    #1;
    chk("R4", 32'(ov2), 0); chk("R4", 32'(ir2), 1);
    chk("R10", 32'(ir1), 0);
    step();
    // R5: broadcast wakes the blocked one
    put(1'b0, '0, '0, 2'b00, 1'b1, 3'd5, 1'b0, 1'b0); step();
    idle(1'b1);
    #1;
    chk("R5", 32'(ov2), 1); chk("R5", 32'(op2), 32'hA0);
    chk("R5", 32'(ov1), 1); chk("R5", 32'(op1), 32'hA0);
    step();

    // R6: capture of a broadcast in the accepting cycle
    put(1'b1, 8'hC0, {3'd3, 3'd3}, 2'b00, 1'b1, 3'd3, 1'b0, 1'b0); step();
    idle(1'b0);
    #1;
    chk("R6", 32'(ov2), 1); chk("R6", 32'(op2), 32'hC0);
    step();
    // R3 / R7 / R8: two ready entries, unit stalled
    put(1'b1, 8'hC1, 6'd0, 2'b11, 1'b0, '0, 1'b0, 1'b0); step();
    idle(1'b0);
    #1;
    chk("R7", 32'(ir2), 0); chk("R3", 32'(op2), 32'hC0); chk("R8", 32'(ov2), 1);
    step();
    idle(1'b1);
    #1;
    chk("R7", 32'(ir2), 1); chk("R3", 32'(op2), 32'hC0);
    step();
    idle(1'b1);
    #1;
    chk("R3", 32'(op2), 32'hC1); chk("R10", 32'(ov1), 0);
    step();
    idle(1'b1); step();

    // R9: flush with a full station
    put(1'b1, 8'hD0, {3'd7, 3'd7}, 2'b00, 1'b0, '0, 1'b0, 1'b0); step();
    put(1'b1, 8'hD1, {3'd7, 3'd7}, 2'b00, 1'b0, '0, 1'b0, 1'b0); step();
    put(1'b1, 8'hD2, 6'd0, 2'b11, 1'b0, '0, 1'b0, 1'b1);
    #1;
    chk("R9", 32'(ir2), 0); chk("R9", 32'(ir1), 0);
    step();
    idle(1'b1);
    #1;
    chk("R9", 32'(ov2), 0); chk("R9", 32'(ir2), 1);
    step();
    put(1'b0, '0, '0, 2'b00, 1'b1, 3'd7, 1'b1, 1'b0); step();
    idle(1'b1);
    #1;
    chk("R9", 32'(ov2), 0); chk("R9", 32'(ov1), 0);
    step();

    // sweep: pseudo-random traffic against the model
    for (int c = 0; c < 4000; c++) begin
      put(($urandom % 4) != 0, 8'(c), 6'($urandom), 2'($urandom),
          ($urandom % 2) == 0, 3'($urandom), ($urandom % 4) != 0,
          ($urandom % 64) == 0);
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule